// File: doc/BRIEF.md
# Serial Grant Chain Bus Arbiter

This block settles ownership of a shared bus among a configurable number of masters that sit on a single chain. All masters contribute to one shared request line. The controller therefore sees only that someone is asking, not who. When the bus is idle and the request line is high, the controller raises a grant at the head of the chain.

The grant travels combinationally from cell to cell. A master that is not asking hands the grant to the next cell in the same cycle. The first asking master keeps the grant and does not pass it on. It takes the bus and drives the shared busy line until it signals that it is finished. Position on the chain is therefore the only priority: index 0 is nearest the controller and always wins.

The block reports the current owner as a one-hot vector, plus the busy flag and the grant entering the chain.

Top module: `dcarb_chain_arbiter`

## Requirements
- R1: After reset, `owner_o`, `busy_o` and `grant_o` are all 0.
- R2: `grant_o` is 1 in the cycle after an edge at which some `req_i` bit was 1 and `busy_o` was 0. Otherwise it is 0 in that cycle.
- R3: One edge after `grant_o` is seen high with the bus free, `owner_o` becomes one-hot at the lowest index whose `req_i` bit is 1 (bit i is master i, index 0 highest priority), and `busy_o` becomes 1.
- R4: At most one bit of `owner_o` is 1 in any cycle, and `busy_o` is 1 exactly when some `owner_o` bit is 1.
- R5: The owner keeps the bus until its own `done_i` bit is 1 at an edge; `done_i` bits of other masters have no effect on `owner_o`.
- R6: The owner keeps the bus even after its `req_i` bit drops, until its `done_i` bit.
- R7: In the cycle after an edge at which `busy_o` was 1, `grant_o` is 0.
- R8: If every request is withdrawn while the grant is travelling, no master becomes owner and `busy_o` stays 0.
- R9: A request from a higher-priority master while the bus is owned does not preempt the owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Per-master bus request; merged into one shared line |
| done_i | input | N_MASTERS | Per-master release strobe; acts only for the owner |
| owner_o | output | N_MASTERS | One-hot current bus owner |
| busy_o | output | 1 | Shared busy line: bus is owned |
| grant_o | output | 1 | Grant entering the chain at position 0 |

## Verification
The bench drives two masters that request together. A chain that forwards the grant past a requester would show two owners or the farther master as owner. It withdraws requests while the grant is in flight; a cell that latched a stale grant would claim the bus with nobody asking. It raises a higher-priority request during ownership and drops the owner's own request before release. A design that re-arbitrated while busy would switch owners, and one that tied ownership to the request would release early. It also strobes `done_i` for masters that do not own the bus; a design that released on any done would free the bus at the wrong time.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;

    typedef struct packed {
        logic grant;
    } ctrl_state_t;

    typedef struct packed {
        logic owns;
    } cell_state_t;

endpackage

// File: rtl/dcarb_lines.sv
module dcarb_lines #(
    parameter int N_MASTERS = 4
) (
    input  logic [N_MASTERS-1:0] req_vec_i,
    input  logic [N_MASTERS-1:0] busy_vec_i,
    output logic                 req_line_o,
    output logic                 busy_line_o
);

    // Shared wired-OR request and busy lines.
    always_comb begin
        req_line_o  = |req_vec_i;
        busy_line_o = |busy_vec_i;
    end

endmodule

// File: rtl/dcarb_ctrl.sv
module dcarb_ctrl
    import dcarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_line_i,
    input  logic busy_line_i,
    output logic grant_o
);

    ctrl_state_t state_d, state_q;

    // Grant only when somebody asks and the bus is free; drop it once busy is seen.
    always_comb begin
        state_d       = state_q;
        state_d.grant = req_line_i & ~busy_line_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_o = state_q.grant;

endmodule

// File: rtl/dcarb_cell.sv
module dcarb_cell
    import dcarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_in_i,
    input  logic req_i,
    input  logic done_i,
    input  logic busy_line_i,
    output logic grant_out_o,
    output logic owns_o
);

    cell_state_t state_d, state_q;
    logic        absorb;

    always_comb begin
        // A requesting cell keeps the grant; an idle cell forwards it unchanged.
        absorb      = grant_in_i & req_i;
        grant_out_o = grant_in_i & ~req_i;

        state_d = state_q;
        if (state_q.owns) begin
            if (done_i) begin
                state_d.owns = 1'b0;
            end
        end else if (absorb && !busy_line_i) begin
            state_d.owns = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign owns_o = state_q.owns;

endmodule

// File: rtl/dcarb_chain_arbiter.sv
module dcarb_chain_arbiter #(
    parameter int N_MASTERS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_MASTERS-1:0] req_i,
    input  logic [N_MASTERS-1:0] done_i,
    output logic [N_MASTERS-1:0] owner_o,
    output logic                 busy_o,
    output logic                 grant_o
);

    localparam int N_LINKS = N_MASTERS + 1;

    logic [N_LINKS-1:0]   chain_grant;
    logic [N_MASTERS-1:0] owns_vec;
    logic                 req_line;
    logic                 busy_line;
    logic                 ctrl_grant;

    dcarb_lines #(.N_MASTERS(N_MASTERS)) u_lines (
        .req_vec_i   (req_i),
        .busy_vec_i  (owns_vec),
        .req_line_o  (req_line),
        .busy_line_o (busy_line)
    );

    dcarb_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_line_i  (req_line),
        .busy_line_i (busy_line),
        .grant_o     (ctrl_grant)
    );

    assign chain_grant[0] = ctrl_grant;

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_cell
        dcarb_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .grant_in_i  (chain_grant[g]),
            .req_i       (req_i[g]),
            .done_i      (done_i[g]),
            .busy_line_i (busy_line),
            .grant_out_o (chain_grant[g+1]),
            .owns_o      (owns_vec[g])
        );
    end

    // Grant leaving the last cell has nowhere to go.
    logic unused_tail;
    assign unused_tail = chain_grant[N_LINKS-1];

    assign owner_o = owns_vec;
    assign busy_o  = busy_line;
    assign grant_o = ctrl_grant;

endmodule

// File: rtl/dcarb_chain_arbiter_chk.sv
module dcarb_chain_arbiter_chk #(
    parameter int N_MASTERS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_MASTERS-1:0] req_i,
    input logic [N_MASTERS-1:0] done_i,
    input logic [N_MASTERS-1:0] owner_o,
    input logic                 busy_o,
    input logic                 grant_o
);

    AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_i) && !busy_o) |=> grant_o); // R2

    AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !((|req_i) && !busy_o) |=> !grant_o); // R2

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(owner_o)); // R4

    AST_BUSY_MEANS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (owner_o != '0)); // R4

    AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner_o & ~done_i) != '0) |=> (owner_o == $past(owner_o))); // R5

    AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !grant_o); // R7

    AST_OWNER_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == 1'b0 && busy_o == 1'b0) |=> !busy_o); // R3

endmodule

bind dcarb_chain_arbiter dcarb_chain_arbiter_chk #(.N_MASTERS(N_MASTERS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .done_i  (done_i),
    .owner_o (owner_o),
    .busy_o  (busy_o),
    .grant_o (grant_o)
);

// File: tb/test_dcarb_chain_arbiter.sv
module test_dcarb_chain_arbiter;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_i = '0;
    logic [N-1:0] done_i = '0;
    logic [N-1:0] owner_o;
    logic         busy_o;
    logic         grant_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dcarb_chain_arbiter #(.N_MASTERS(N)) i_dcarb_chain_arbiter (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .done_i  (done_i),
        .owner_o (owner_o),
        .busy_o  (busy_o),
        .grant_o (grant_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [N-1:0] own_exp, logic busy_exp, logic gnt_exp);
        n_checks++;
        if (owner_o !== own_exp || busy_o !== busy_exp || grant_o !== gnt_exp) begin
            n_fails++;
            $display("FAIL %s: owner=%b busy=%b grant=%b expected owner=%b busy=%b grant=%b",
                     tag, owner_o, busy_o, grant_o, own_exp, busy_exp, gnt_exp);
        end
    endtask

    task automatic release_bus(int idx);
        req_i[idx]  = 1'b0;
        done_i[idx] = 1'b1;
        tick();
        done_i = '0;
    endtask

    task automatic t_reset();
        check("R1 reset", 4'b0000, 1'b0, 1'b0);
        tick();
        check("R1 idle after reset", 4'b0000, 1'b0, 1'b0);
    endtask

    task automatic t_single();
        req_i = 4'b0100;
        tick();
        check("R2 grant raised", 4'b0000, 1'b0, 1'b1);
        tick();
        check("R3 single owner", 4'b0100, 1'b1, 1'b1);
        tick();
        check("R7 grant dropped", 4'b0100, 1'b1, 1'b0);
        done_i = 4'b1011;
        tick();
        done_i = '0;
        check("R5 foreign done ignored", 4'b0100, 1'b1, 1'b0);
        release_bus(2);
        check("R5 own done releases", 4'b0000, 1'b0, 1'b0);
    endtask

    task automatic t_priority();
        req_i = 4'b1010;
        tick();
        tick();
        check("R3 nearest wins", 4'b0010, 1'b1, 1'b1);
        tick();
        check("R4 single owner held", 4'b0010, 1'b1, 1'b0);
        release_bus(1);
        check("R4 released, no grant yet", 4'b0000, 1'b0, 1'b0);
        tick();
        check("R2 regrant to farther", 4'b0000, 1'b0, 1'b1);
        tick();
        check("R3 farther master owns", 4'b1000, 1'b1, 1'b1);
        release_bus(3);
        tick();
    endtask

    task automatic t_no_preempt();
        req_i = 4'b0100;
        tick();
        tick();
        req_i = 4'b0101;
        tick();
        check("R9 owner kept", 4'b0100, 1'b1, 1'b0);
        tick();
        tick();
        check("R9 still no preemption", 4'b0100, 1'b1, 1'b0);
        req_i[0] = 1'b0;
        release_bus(2);
        tick();
    endtask

    task automatic t_withdraw();
        req_i = 4'b0010;
        tick();
        check("R8 grant in flight", 4'b0000, 1'b0, 1'b1);
        req_i = '0;
        tick();
        check("R8 no owner after withdraw", 4'b0000, 1'b0, 1'b0);
        tick();
        check("R8 stays idle", 4'b0000, 1'b0, 1'b0);
    endtask

    task automatic t_hold_after_drop();
        req_i = 4'b0001;
        tick();
        tick();
        req_i = '0;
        tick();
        check("R6 owner holds without request", 4'b0001, 1'b1, 1'b0);
        tick();
        check("R6 still owner", 4'b0001, 1'b1, 1'b0);
        done_i = 4'b0001;
        tick();
        done_i = '0;
        check("R6 done releases", 4'b0000, 1'b0, 1'b0);
    endtask

    initial begin
        #1;
        check("R1 in reset", 4'b0000, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_priority();
        t_no_preempt();
        t_withdraw();
        t_hold_after_drop();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule